// File: doc/BRIEF.md
# Sideband Inbound Message Receiver

This block takes one inbound sideband request at a time from a parallel valid/ready port and holds it in read-only registers. It then raises an interrupt to the local processor. Firmware reads the held message and signals that it is done by writing a completion request. If the held request was non-posted, the block sends a completion on a parallel valid/ready port. The completion carries a status code and a data word that firmware set up beforehand. If the request was posted, the block simply releases the holding buffer. Inbound traffic is accepted only while firmware has set an access-enable bit. A second message can never overwrite one that is still held.

The control flow is a three-state machine.
- `ST_IDLE`: the buffer is empty, and inbound ready follows the access-enable bit. The transition *accept* (valid and ready both high) moves to `ST_HELD`.
- `ST_HELD`: the message is held, the received status reads 1, and inbound ready is low. The transition *release_np* goes to `ST_SEND`. It fires on a completion-request write when the held type is non-posted. The transition *release_p* goes back to `ST_IDLE`. It fires on the same write for any other type.
- `ST_SEND`: completion valid is high and the completion payload is frozen. The transition *cpl_done* (completion ready seen) returns to `ST_IDLE`.

The register bus is a 4-bit word index with a write strobe. Read data is combinational from the index. The map is as follows:

| Index | Contents |
|---|---|
| 0 | message attributes |
| 1 | low address |
| 2 | high address |
| 3 | security |
| 4 | message data |
| 5 | control |
| 6 | enable |
| 7 | completion command |
| 8 | completion data |

Any other index reads 0.

Top module: `sbrx_top`

## Requirements
- R1: After reset, `in_ready`, `cpl_valid` and `irq` are 0, and every register reads 0.
- R2: `in_ready` is 1 exactly when the enable register bit 0 is 1 and no message is held. While the enable bit is 0, a presented message is not captured.
- R3: On accept, the attribute word (index 0) holds destination ID in bits 7:0, source ID in bits 15:8, opcode in bits 23:16 and byte enables in bits 27:24. Bits 31:28 read 0.
- R4: On accept, the following fields are captured:
  - index 1 holds the low 32 address bits;
  - index 2 holds the upper 16 address bits in 15:0 and the address-length flag in bit 31 (0 = 16-bit address, 1 = 48-bit address);
  - index 3 holds the 16-bit security attribute in 15:0, the root space in 19:16 and the extended-header flag in bit 31;
  - index 4 holds the data word;
  - index 5 bits 1:0 hold the transaction type (01 posted, 10 non-posted, 11 completion).
- R5: The received status (index 5 bit 31) reads 1 from the cycle after accept until the message is released. `irq` equals the received status ANDed with the inverse of the mask (index 5 bit 30, read/write). The mask never changes the status.
- R6: Firmware writes index 7 with bit 31 set while a non-posted message is held. From the next cycle `cpl_valid` is 1, `cpl_status` carries bits 2:0 of that write (000 success, 001 unsupported request), and `cpl_data` carries the index 8 value. `cpl_dst` is the held source ID and `cpl_src` is the held destination ID. Index 7 bit 31 reads 1 while the completion is pending.
- R7: `cpl_valid` and the completion payload stay unchanged until `cpl_ready` is seen. On the cycle after that handshake, `cpl_valid`, the received status and index 7 bit 31 read 0.
- R8: Firmware writes index 7 with bit 31 set while a posted or completion-type message is held. No completion is sent, and the received status and `irq` read 0 from the next cycle.
- R9: The following index 7 writes start no completion and release nothing: a write with bit 31 clear, and any write while no message is held.
- R10: While a message is held, `in_ready` is 0 and a further presented message leaves the captured registers unchanged.
- R11: While a completion is pending, writes to index 7 and index 8 do not change `cpl_status` or `cpl_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| in_valid | input | 1 | inbound message valid |
| in_ready | output | 1 | inbound message ready |
| in_dst | input | 8 | destination port ID |
| in_src | input | 8 | source port ID |
| in_opc | input | 8 | opcode |
| in_be | input | 4 | byte enables |
| in_ttype | input | 2 | transaction type |
| in_alen | input | 1 | address-length flag |
| in_addr_lo | input | 32 | low address bits |
| in_addr_hi | input | 16 | upper address bits |
| in_ehp | input | 1 | extended-header flag |
| in_sai | input | 16 | security attribute |
| in_rs | input | 4 | root space |
| in_data | input | 32 | data word |
| cpl_valid | output | 1 | completion valid |
| cpl_ready | input | 1 | completion ready |
| cpl_dst | output | 8 | completion destination ID |
| cpl_src | output | 8 | completion source ID |
| cpl_status | output | 3 | completion status |
| cpl_data | output | 32 | completion data |
| reg_addr | input | 4 | register word index |
| reg_wr | input | 1 | register write strobe |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data |
| irq | output | 1 | interrupt to processor |

## Verification
The bench goes after the following corner cases, each of which a faulty design would get wrong in a visible way:

- **Posted release.** A design that ignored the transaction type would emit a stray completion for a posted message.
- **Back-pressured completion.** A design that dropped valid or reloaded the payload early would lose or corrupt the completion under back-pressure.
- **Mask versus status.** A design that tied the mask into the status would show a cleared received bit while masked.
- **Second message.** A design that left ready high while holding would let it overwrite the held fields.
- **Disabled access and stray requests.** The bench also presents a message with access disabled, and writes stray completion requests while idle or with bit 31 clear. In both cases a careless design would capture the message or fire a completion.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;

    localparam int WORD_W = 32;
    localparam int PID_W  = 8;
    localparam int OPC_W  = 8;
    localparam int BE_W   = 4;
    localparam int HI_W   = 16;
    localparam int SAI_W  = 16;
    localparam int RS_W   = 4;
    localparam int STS_W  = 3;
    localparam int IDX_W  = 4;

    localparam logic [1:0] TT_POSTED  = 2'b01;
    localparam logic [1:0] TT_NONPOST = 2'b10;
    localparam logic [1:0] TT_CPL     = 2'b11;

    localparam logic [IDX_W-1:0] IX_ATTR  = 4'd0;
    localparam logic [IDX_W-1:0] IX_ALO   = 4'd1;
    localparam logic [IDX_W-1:0] IX_AHI   = 4'd2;
    localparam logic [IDX_W-1:0] IX_SEC   = 4'd3;
    localparam logic [IDX_W-1:0] IX_DATA  = 4'd4;
    localparam logic [IDX_W-1:0] IX_CTRL  = 4'd5;
    localparam logic [IDX_W-1:0] IX_EN    = 4'd6;
    localparam logic [IDX_W-1:0] IX_CCMD  = 4'd7;
    localparam logic [IDX_W-1:0] IX_CDATA = 4'd8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_SEND = 2'd2
    } sbrx_state_e;

    typedef struct packed {
        logic [PID_W-1:0]  dst;
        logic [PID_W-1:0]  src;
        logic [OPC_W-1:0]  opc;
        logic [BE_W-1:0]   be;
        logic [1:0]        ttype;
        logic              alen;
        logic [WORD_W-1:0] addr_lo;
        logic [HI_W-1:0]   addr_hi;
        logic              ehp;
        logic [SAI_W-1:0]  sai;
        logic [RS_W-1:0]   rs;
        logic [WORD_W-1:0] data;
    } sbrx_msg_t;

endpackage

// File: rtl/sbrx_capture.sv
module sbrx_capture
    import sbrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  sbrx_msg_t msg_in,
    output sbrx_msg_t msg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q <= '0;
        end else if (load) begin
            msg_q <= msg_in;
        end
    end

endmodule

// File: rtl/sbrx_fsm.sv
module sbrx_fsm
    import sbrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic acc_en,
    input  logic is_np,
    input  logic req_pulse,
    input  logic cpl_ready,
    output logic in_ready,
    output logic cap_load,
    output logic held,
    output logic sending
);

    sbrx_state_e state_q;
    sbrx_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && acc_en) begin
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (req_pulse) begin
                    state_d = is_np ? ST_SEND : ST_IDLE;
                end
            end
            ST_SEND: begin
                if (cpl_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready = 1'b0;
        held     = 1'b0;
        sending  = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = acc_en;
            ST_HELD: held     = 1'b1;
            ST_SEND: begin
                held    = 1'b1;
                sending = 1'b1;
            end
            default: ;
        endcase
        cap_load = in_valid && in_ready;
    end

endmodule

// File: rtl/sbrx_regs.sv
module sbrx_regs
    import sbrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  sbrx_msg_t         msg_q,
    input  logic              held,
    input  logic              sending,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              acc_en,
    output logic              mask,
    output logic              req_pulse,
    output logic [STS_W-1:0]  cpl_status,
    output logic [WORD_W-1:0] cpl_data
);

    logic wr_ctrl;
    logic wr_en;
    logic wr_ccmd;
    logic wr_cdata;

    assign wr_ctrl  = reg_wr && (reg_addr == IX_CTRL);
    assign wr_en    = reg_wr && (reg_addr == IX_EN);
    assign wr_ccmd  = reg_wr && (reg_addr == IX_CCMD);
    assign wr_cdata = reg_wr && (reg_addr == IX_CDATA);

    assign req_pulse = wr_ccmd && reg_wdata[WORD_W-1] && held && !sending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_en     <= 1'b0;
            mask       <= 1'b0;
            cpl_status <= '0;
            cpl_data   <= '0;
        end else begin
            if (wr_en) begin
                acc_en <= reg_wdata[0];
            end
            if (wr_ctrl) begin
                mask <= reg_wdata[WORD_W-2];
            end
            if (wr_ccmd && !sending) begin
                cpl_status <= reg_wdata[STS_W-1:0];
            end
            if (wr_cdata && !sending) begin
                cpl_data <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            IX_ATTR:  reg_rdata = {{(WORD_W-BE_W-OPC_W-2*PID_W){1'b0}},
                                   msg_q.be, msg_q.opc, msg_q.src, msg_q.dst};
            IX_ALO:   reg_rdata = msg_q.addr_lo;
            IX_AHI:   reg_rdata = {msg_q.alen, {(WORD_W-1-HI_W){1'b0}}, msg_q.addr_hi};
            IX_SEC:   reg_rdata = {msg_q.ehp, {(WORD_W-1-RS_W-SAI_W){1'b0}},
                                   msg_q.rs, msg_q.sai};
            IX_DATA:  reg_rdata = msg_q.data;
            IX_CTRL:  reg_rdata = {held, mask, {(WORD_W-4){1'b0}}, msg_q.ttype};
            IX_EN:    reg_rdata = {{(WORD_W-1){1'b0}}, acc_en};
            IX_CCMD:  reg_rdata = {sending, {(WORD_W-1-STS_W){1'b0}}, cpl_status};
            IX_CDATA: reg_rdata = cpl_data;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sbrx_top.sv
module sbrx_top
    import sbrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_dst,
    input  logic [7:0]  in_src,
    input  logic [7:0]  in_opc,
    input  logic [3:0]  in_be,
    input  logic [1:0]  in_ttype,
    input  logic        in_alen,
    input  logic [31:0] in_addr_lo,
    input  logic [15:0] in_addr_hi,
    input  logic        in_ehp,
    input  logic [15:0] in_sai,
    input  logic [3:0]  in_rs,
    input  logic [31:0] in_data,
    output logic        cpl_valid,
    input  logic        cpl_ready,
    output logic [7:0]  cpl_dst,
    output logic [7:0]  cpl_src,
    output logic [2:0]  cpl_status,
    output logic [31:0] cpl_data,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    sbrx_msg_t msg_in;
    sbrx_msg_t msg_q;
    logic      cap_load;
    logic      held;
    logic      sending;
    logic      acc_en;
    logic      mask;
    logic      req_pulse;

    always_comb begin
        msg_in.dst     = in_dst;
        msg_in.src     = in_src;
        msg_in.opc     = in_opc;
        msg_in.be      = in_be;
        msg_in.ttype   = in_ttype;
        msg_in.alen    = in_alen;
        msg_in.addr_lo = in_addr_lo;
        msg_in.addr_hi = in_addr_hi;
        msg_in.ehp     = in_ehp;
        msg_in.sai     = in_sai;
        msg_in.rs      = in_rs;
        msg_in.data    = in_data;
    end

    sbrx_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cap_load),
        .msg_in (msg_in),
        .msg_q  (msg_q)
    );

    sbrx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .acc_en    (acc_en),
        .is_np     (msg_q.ttype == TT_NONPOST),
        .req_pulse (req_pulse),
        .cpl_ready (cpl_ready),
        .in_ready  (in_ready),
        .cap_load  (cap_load),
        .held      (held),
        .sending   (sending)
    );

    sbrx_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .msg_q      (msg_q),
        .held       (held),
        .sending    (sending),
        .reg_rdata  (reg_rdata),
        .acc_en     (acc_en),
        .mask       (mask),
        .req_pulse  (req_pulse),
        .cpl_status (cpl_status),
        .cpl_data   (cpl_data)
    );

    assign cpl_valid = sending;
    assign cpl_dst   = msg_q.src;
    assign cpl_src   = msg_q.dst;
    assign irq       = held && !sending ? !mask : (sending && !mask);

endmodule

// File: rtl/sbrx_chk.sv
module sbrx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        cpl_valid,
    input logic        cpl_ready,
    input logic [2:0]  cpl_status,
    input logic [31:0] cpl_data,
    input logic        reg_wr,
    input logic        irq,
    input logic        acc_en,
    input logic        mask
);

    // R2
    ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> !in_ready);

    // R10
    no_second_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq);

    // R7
    cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_status) && $stable(cpl_data)));

    // R6
    cpl_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpl_valid) |-> $past(reg_wr));

    // R7
    cpl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> !cpl_valid);

endmodule

bind sbrx_top sbrx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .cpl_valid  (cpl_valid),
    .cpl_ready  (cpl_ready),
    .cpl_status (cpl_status),
    .cpl_data   (cpl_data),
    .reg_wr     (reg_wr),
    .irq        (irq),
    .acc_en     (acc_en),
    .mask       (mask)
);

// File: tb/sbrx_top_bench.sv
module sbrx_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_dst = '0, in_src = '0, in_opc = '0;
    logic [3:0]  in_be = '0, in_rs = '0;
    logic [1:0]  in_ttype = '0;
    logic        in_alen = 1'b0, in_ehp = 1'b0;
    logic [31:0] in_addr_lo = '0, in_data = '0;
    logic [15:0] in_addr_hi = '0, in_sai = '0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [7:0]  cpl_dst, cpl_src;
    logic [2:0]  cpl_status;
    logic [31:0] cpl_data;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // expected copy of the held message
    logic [7:0]  e_dst, e_src, e_opc;
    logic [3:0]  e_be, e_rs;
    logic [1:0]  e_tt;
    logic        e_alen, e_ehp, e_mask;
    logic [31:0] e_alo, e_data;
    logic [15:0] e_ahi, e_sai;

    sbrx_top u_sbrx_top (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    function automatic logic [31:0] f_attr();
        return {4'b0, e_be, e_opc, e_src, e_dst};
    endfunction
    function automatic logic [31:0] f_ahi();
        return {e_alen, 15'b0, e_ahi};
    endfunction
    function automatic logic [31:0] f_sec();
        return {e_ehp, 11'b0, e_rs, e_sai};
    endfunction

    task automatic rand_msg(input logic [1:0] tt);
        e_dst = 8'($urandom); e_src = 8'($urandom); e_opc = 8'($urandom);
        e_be = 4'($urandom); e_rs = 4'($urandom); e_tt = tt;
        e_alen = 1'($urandom); e_ehp = 1'($urandom);
        e_alo = $urandom; e_data = $urandom;
        e_ahi = 16'($urandom); e_sai = 16'($urandom);
    endtask

    task automatic drive_msg();
        in_dst = e_dst; in_src = e_src; in_opc = e_opc; in_be = e_be;
        in_ttype = e_tt; in_alen = e_alen; in_addr_lo = e_alo;
        in_addr_hi = e_ahi; in_ehp = e_ehp; in_sai = e_sai; in_rs = e_rs;
        in_data = e_data;
        in_valid = 1'b1;
    endtask

    task automatic check_held();
        logic [31:0] d;
        rd(4'd0, d); chk("R3 attr", d, f_attr());
        rd(4'd1, d); chk("R4 addr_lo", d, e_alo);
        rd(4'd2, d); chk("R4 addr_hi", d, f_ahi());
        rd(4'd3, d); chk("R4 sec", d, f_sec());
        rd(4'd4, d); chk("R4 data", d, e_data);
        rd(4'd5, d); chk("R5 ctrl", d, {1'b1, e_mask, 28'b0, e_tt});
        chk("R5 irq", {31'b0, irq}, {31'b0, !e_mask});
    endtask

    initial begin
        logic [31:0] d;
        logic [2:0]  sts;
        logic [31:0] cdat;
        int          dly;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", {31'b0, in_ready}, 32'd0);
        chk("R1 cpl_valid", {31'b0, cpl_valid}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        for (int i = 0; i < 9; i++) begin
            rd(4'(i), d);
            chk("R1 reg", d, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 access disabled: nothing captured
        e_mask = 1'b0;
        rand_msg(2'b01);
        drive_msg();
        #1 chk("R2 ready low when disabled", {31'b0, in_ready}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rd(4'd0, d); chk("R2 no capture", d, 32'd0);
        rd(4'd5, d); chk("R2 no status", d, 32'd0);

        // R9 request while idle
        wr(4'd7, 32'h8000_0000);
        chk("R9 idle req no cpl", {31'b0, cpl_valid}, 32'd0);
        rd(4'd7, d); chk("R9 idle req bit", d[31], 1'b0);

        wr(4'd6, 32'd1);
        #1 chk("R2 ready high when enabled", {31'b0, in_ready}, 32'd1);

        for (int it = 0; it < 60; it++) begin
            e_mask = 1'($urandom);
            wr(4'd5, {1'b0, e_mask, 30'b0});
            rand_msg(2'(1 + ($urandom % 3)));
            drive_msg();
            #1 chk("R2 ready", {31'b0, in_ready}, 32'd1);
            @(negedge clk);
            in_valid = 1'b0;
            check_held();

            // R10 second message blocked
            drive_msg();
            in_dst = ~e_dst; in_data = ~e_data;
            #1 chk("R10 ready low", {31'b0, in_ready}, 32'd0);
            @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            rd(4'd0, d); chk("R10 attr kept", d, f_attr());
            rd(4'd4, d); chk("R10 data kept", d, e_data);

            // R9 request bit clear ignored
            wr(4'd7, 32'h0000_0001);
            rd(4'd5, d); chk("R9 bit31 clear keeps status", d[31], 1'b1);
            chk("R9 bit31 clear no cpl", {31'b0, cpl_valid}, 32'd0);

            if (e_tt != 2'b10) begin
                wr(4'd7, 32'h8000_0000);
                chk("R8 no cpl", {31'b0, cpl_valid}, 32'd0);
                rd(4'd5, d); chk("R8 status clear", d[31], 1'b0);
                chk("R8 irq clear", {31'b0, irq}, 32'd0);
                @(negedge clk);
                chk("R8 still no cpl", {31'b0, cpl_valid}, 32'd0);
            end else begin
                sts  = 3'($urandom % 2);
                cdat = $urandom;
                wr(4'd8, cdat);
                wr(4'd7, {1'b1, 28'b0, sts});
                chk("R6 cpl_valid", {31'b0, cpl_valid}, 32'd1);
                chk("R6 status", {29'b0, cpl_status}, {29'b0, sts});
                chk("R6 data", cpl_data, cdat);
                chk("R6 dst", {24'b0, cpl_dst}, {24'b0, e_src});
                chk("R6 src", {24'b0, cpl_src}, {24'b0, e_dst});
                rd(4'd7, d); chk("R6 pending bit", d[31], 1'b1);
                dly = $urandom % 4;
                for (int k = 0; k < dly; k++) begin
                    wr(4'd8, ~cdat);
                    chk("R7 held valid", {31'b0, cpl_valid}, 32'd1);
                    chk("R11 data frozen", cpl_data, cdat);
                end
                wr(4'd7, 32'h0000_0007);
                chk("R11 status frozen", {29'b0, cpl_status}, {29'b0, sts});
                cpl_ready = 1'b1;
                @(negedge clk);
                cpl_ready = 1'b0;
                chk("R7 valid drop", {31'b0, cpl_valid}, 32'd0);
                rd(4'd5, d); chk("R7 status clear", d[31], 1'b0);
                rd(4'd7, d); chk("R7 pending clear", d[31], 1'b0);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule